// File: doc/BRIEF.md
# Bit-Pipelined Carry Accumulator

This block adds a small unsigned operand to a narrow running sum on every clock. It is built so that no carry ever travels through more than one bit position in one cycle. Each bit position is a slice that holds one sum flop and one carry flop. A carry born in slice `i` is absorbed by slice `i+1` on the next edge. Operand bit `i` is held back by `i` register stages, so it reaches its slice in the same cycle as the carries produced by the same operand. The sum is therefore exact, but it is spread over time. The value in the sum flops is only the complete total once nothing is left in flight.

A carry out of the top slice is the wrap event. It leaves the block as a one-cycle pulse meant to drive a wide counter outside the block. That counter holds the high-order part of the integration, and the sum flops hold the residue. After any run of operands followed by a drain, the pulse count times 2^SUM_W plus the residue equals the exact sum of the operands. The `idle_o` flag tells the reader when the residue can be taken: it is high when no operand bit and no internal carry are still travelling.

A synchronous clear zeroes the sum, carry and skew flops in one edge. Any partial sum still in flight at that moment is discarded. An asynchronous active-low reset does the same.

Top module: `bitpipe_accum`

## Requirements
- R1: After reset, or on the edge after `clr_i` is sampled high, `sum_o` is 0, `wrap_o` is 0 and `idle_o` is 1. The operand presented in a clear cycle is discarded, and so is any carry or operand bit that was in flight.
- R2: Each operand on `op_i` that is sampled at an edge outside reset and clear is added as an unsigned OP_W-bit integer. Whenever `idle_o` is high, (number of `wrap_o` pulses since the last clear) × 2^SUM_W + `sum_o` equals the sum of the operands accepted since that clear.
- R3: Operand bit `i` enters sum bit `i` on the (i+1)-th edge after the operand is sampled. Starting from an idle sum of 0 with default parameters, operand 5 gives `sum_o` = 1 after one edge, still 1 after two edges, and 5 with `idle_o` high after three edges.
- R4: A carry advances exactly one bit position per edge. Starting from an idle sum of 2^SUM_W−1, operand 1 gives `sum_o` = 14, 12, 8 and then 0 after edges one to four (default parameters). `wrap_o` is high only after the fourth edge, which is edge SUM_W.
- R5: `wrap_o` is high for single cycles only and is never high in two consecutive cycles. While it is high, the top bit of `sum_o` is 0.
- R6: `idle_o` is high exactly when no carry below the top slice and no delayed operand bit is pending. While `idle_o` is high, a zero operand leaves `sum_o` unchanged, keeps `idle_o` high and raises no `wrap_o`.
- R7: For long random streams of operands in the range 0 to 6, followed by SUM_W zero operands, `idle_o` is high and the pulse count and residue reproduce the exact stream sum.
- R8: The parameters must satisfy SUM_W ≥ 2 and 1 ≤ OP_W ≤ SUM_W. Any other setting stops elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous clear of all sum, carry and skew flops |
| op_i | input | OP_W | Unsigned operand added on every edge |
| sum_o | output | SUM_W | Sum flops (residue); exact while `idle_o` is high |
| wrap_o | output | 1 | One-cycle pulse on a carry out of the top bit |
| idle_o | output | 1 | No carry or operand bit in flight |

## Verification
The bench targets the timing of the staggered slices. It checks the exact per-edge sums for a lone operand with a gap bit (5) and for a carry that ripples through an all-ones sum. A design that skewed the operand bits by the wrong depth, or that let a carry skip a stage, would show the wrong intermediate values or raise the wrap pulse early. A long random stream is checked against a behavioural running total on every cycle where the block reports idle. This exposes lost or doubled carries, a wrap pulse that is stretched or repeated, and an idle flag that rises while bits are still travelling. A clear issued in the middle of a stream with carries pending must leave a clean zero. A design that left skew or carry flops uncleared would have stale bits leak into the next integration.

// File: rtl/bpa_pkg.sv
package bpa_pkg;

   // Role of one bit slice in the carry pipeline.
   typedef enum logic [1:0] {
      SLICE_HALF  = 2'd0,  // bit 0: operand bit only, no incoming carry
      SLICE_FULL  = 2'd1,  // skewed operand bit plus carry from below
      SLICE_CARRY = 2'd2   // above the operand width: carry from below only
   } slice_kind_e;

   function automatic slice_kind_e slice_kind(input int unsigned idx, input int unsigned op_w);
      if (idx == 0)
         return SLICE_HALF;
      else if (idx < op_w)
         return SLICE_FULL;
      else
         return SLICE_CARRY;
   endfunction

   // Number of delay stages in front of a given operand bit.
   function automatic int unsigned skew_depth(input int unsigned idx);
      return idx;
   endfunction

endpackage

// File: rtl/bpa_skew_line.sv
// Delay line that holds one operand bit back until the carries of the
// same operand have reached its slice.
module bpa_skew_line #(
   parameter int unsigned DEPTH = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic bit_i,
   output logic bit_o,
   output logic busy_o
);

   if (DEPTH < 1) begin : g_bad_depth
      $error("bpa_skew_line: DEPTH must be at least 1");
   end

   logic [DEPTH-1:0] stage_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage_q <= '0;
      end else if (clr_i) begin
         stage_q <= '0;
      end else begin
         stage_q[0] <= bit_i;
         for (int k = 1; k < int'(DEPTH); k++) begin
            stage_q[k] <= stage_q[k-1];
         end
      end
   end

   assign bit_o  = stage_q[DEPTH-1];
   assign busy_o = |stage_q;

endmodule

// File: rtl/bpa_slice.sv
// One bit of the accumulator: a sum flop and a carry flop.
// inc_i counts the ones arriving this cycle (operand bit plus carry).
module bpa_slice (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clr_i,
   input  logic [1:0] inc_i,
   output logic       sum_o,
   output logic       carry_o
);

   logic [1:0] next_val;

   assign next_val = {1'b0, sum_o} + inc_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sum_o   <= 1'b0;
         carry_o <= 1'b0;
      end else if (clr_i) begin
         sum_o   <= 1'b0;
         carry_o <= 1'b0;
      end else begin
         sum_o   <= next_val[0];
         carry_o <= next_val[1];
      end
   end

endmodule

// File: rtl/bitpipe_accum.sv
// Accumulator whose carry chain is cut into single-bit register stages.
module bitpipe_accum #(
   parameter int unsigned SUM_W = 4,
   parameter int unsigned OP_W  = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic [OP_W-1:0]  op_i,
   output logic [SUM_W-1:0] sum_o,
   output logic             wrap_o,
   output logic             idle_o
);
   import bpa_pkg::*;

   localparam int unsigned TOP = SUM_W - 1;

   // R8: parameter legality
   if (SUM_W < 2) begin : g_bad_sum_w
      $error("bitpipe_accum: SUM_W must be at least 2");
   end
   if (OP_W < 1 || OP_W > SUM_W) begin : g_bad_op_w
      $error("bitpipe_accum: OP_W must lie in 1..SUM_W");
   end

   logic [SUM_W-1:0] sum_bit;
   logic [SUM_W-1:0] carry_q;
   logic [SUM_W-1:0] lane_busy;

   for (genvar i = 0; i < int'(SUM_W); i++) begin : g_slice
      localparam slice_kind_e KIND = slice_kind(i, OP_W);
      logic [1:0] inc;

      if (KIND == SLICE_HALF) begin : g_half
         // Bit 0 needs no skew; half add with the sum bit.
         assign inc          = {1'b0, op_i[0]};
         assign lane_busy[i] = 1'b0;
      end else if (KIND == SLICE_FULL) begin : g_full
         logic lane_bit;
         bpa_skew_line #(
            .DEPTH (skew_depth(i))
         ) u_skew (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr_i  (clr_i),
            .bit_i  (op_i[i]),
            .bit_o  (lane_bit),
            .busy_o (lane_busy[i])
         );
         assign inc = {1'b0, lane_bit} + {1'b0, carry_q[i-1]};
      end else begin : g_carry
         assign inc          = {1'b0, carry_q[i-1]};
         assign lane_busy[i] = 1'b0;
      end

      bpa_slice u_bit (
         .clk     (clk),
         .rst_n   (rst_n),
         .clr_i   (clr_i),
         .inc_i   (inc),
         .sum_o   (sum_bit[i]),
         .carry_o (carry_q[i])
      );
   end

   assign sum_o  = sum_bit;
   assign wrap_o = carry_q[TOP];
   assign idle_o = ~(|lane_busy) & ~(|carry_q[TOP-1:0]);

endmodule

// File: rtl/bpa_checker.sv
// Temporal properties of bitpipe_accum, attached through bind.
module bpa_checker #(
   parameter int unsigned SUM_W = 4,
   parameter int unsigned OP_W  = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             clr_i,
   input logic [OP_W-1:0]  op_i,
   input logic [SUM_W-1:0] sum_o,
   input logic             wrap_o,
   input logic             idle_o
);

   // R1: clear empties everything
   assert_clear_empties_R1: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> (sum_o == '0) && !wrap_o && idle_o);

   // R5: wrap pulse is isolated
   assert_wrap_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      wrap_o |=> !wrap_o);

   // R5: top sum bit is cleared in the wrap cycle
   assert_wrap_top_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      wrap_o |-> !sum_o[SUM_W-1]);

   // R6: zero operand while idle holds the residue
   assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (idle_o && !clr_i && (op_i == '0)) |=> $stable(sum_o) && idle_o && !wrap_o);

   // R2: adding one to an even idle residue is an immediate exact increment
   assert_idle_incr_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (idle_o && !clr_i && (op_i == OP_W'(1)) && !sum_o[0])
      |=> (sum_o == $past(sum_o) + SUM_W'(1)) && idle_o);

endmodule

bind bitpipe_accum bpa_checker #(
   .SUM_W (SUM_W),
   .OP_W  (OP_W)
) u_bpa_checker (
   .clk    (clk),
   .rst_n  (rst_n),
   .clr_i  (clr_i),
   .op_i   (op_i),
   .sum_o  (sum_o),
   .wrap_o (wrap_o),
   .idle_o (idle_o)
);

// File: tb/tb_bitpipe_accum.sv
module tb_bitpipe_accum;

   localparam int SUM_W = 4;
   localparam int OP_W  = 3;
   localparam int MODV  = 1 << SUM_W;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             clr_i = 1'b0;
   logic [OP_W-1:0]  op_i = '0;
   logic [SUM_W-1:0] sum_o;
   logic             wrap_o;
   logic             idle_o;

   int    n_checks = 0;
   int    n_fails  = 0;
   bit    done     = 1'b0;
   longint total   = 0;   // reference: operands accepted since clear
   longint pulses  = 0;   // wrap pulses seen since clear
   bit    prev_wrap = 1'b0;

   always #10 clk = ~clk;

   bitpipe_accum #(.SUM_W(SUM_W), .OP_W(OP_W)) dut (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (clr_i),
      .op_i   (op_i),
      .sum_o  (sum_o),
      .wrap_o (wrap_o),
      .idle_o (idle_o)
   );

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   // One clock: drive, let the edge happen, update reference, sample at negedge.
   task automatic step(input int v, input bit c);
      op_i  = OP_W'(v);
      clr_i = c;
      @(posedge clk);
      if (c) begin
         total  = 0;
         pulses = 0;
      end else begin
         total += v;
      end
      @(negedge clk);
      if (wrap_o) begin
         check(!prev_wrap, "R5 wrap in consecutive cycles", 1, 0);
         check(!sum_o[SUM_W-1], "R5 top bit during wrap", sum_o[SUM_W-1], 0);
         pulses++;
      end
      prev_wrap = wrap_o;
      if (idle_o)
         check(pulses * MODV + sum_o == total, "R2 pulses*2^W+residue",
               pulses * MODV + sum_o, total);
   endtask

   task automatic drain();
      for (int k = 0; k < SUM_W; k++) step(0, 1'b0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
         $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      check(sum_o == 0, "R1 sum after reset", sum_o, 0);
      check(!wrap_o, "R1 wrap after reset", wrap_o, 0);
      check(idle_o, "R1 idle after reset", idle_o, 1);

      // R3: operand 5 from zero, bit 2 lands on the third edge
      step(5, 1'b0);
      check(sum_o == 1, "R3 sum after edge 1", sum_o, 1);
      check(!idle_o, "R6 busy while bit 2 in flight", idle_o, 0);
      step(0, 1'b0);
      check(sum_o == 1, "R3 sum after edge 2", sum_o, 1);
      step(0, 1'b0);
      check(sum_o == 5, "R3 sum after edge 3", sum_o, 5);
      check(idle_o, "R3 idle after edge 3", idle_o, 1);

      // R6: zeros while idle change nothing
      step(0, 1'b0);
      step(0, 1'b0);
      check(sum_o == 5 && idle_o && !wrap_o, "R6 hold on zero operands", sum_o, 5);

      // R4: build an all-ones residue, then add 1 and watch the carry walk
      step(7, 1'b0); drain();
      step(3, 1'b0); drain();
      check(sum_o == 15 && idle_o && pulses == 0, "R4 setup residue 15", sum_o, 15);
      step(1, 1'b0);
      check(sum_o == 14 && !wrap_o, "R4 after edge 1", sum_o, 14);
      step(0, 1'b0);
      check(sum_o == 12 && !wrap_o, "R4 after edge 2", sum_o, 12);
      step(0, 1'b0);
      check(sum_o == 8 && !wrap_o, "R4 after edge 3", sum_o, 8);
      step(0, 1'b0);
      check(sum_o == 0 && wrap_o, "R4 wrap after edge 4", {wrap_o, sum_o}, 16);
      step(0, 1'b0);
      check(!wrap_o && idle_o, "R5 wrap lasts one cycle", wrap_o, 0);

      // R1: clear with carries in flight
      step(7, 1'b0);
      step(7, 1'b0);
      step(6, 1'b1);
      check(sum_o == 0 && !wrap_o && idle_o, "R1 clear mid-flight", sum_o, 0);
      step(0, 1'b0);
      step(0, 1'b0);
      check(sum_o == 0 && idle_o, "R1 nothing leaks after clear", sum_o, 0);

      // R7: long random streams 0..6, with a mid-run clear
      for (int run = 0; run < 3; run++) begin
         step(0, 1'b1);
         for (int n = 0; n < 1500; n++) step(int'($urandom % 7), 1'b0);
         drain();
         check(idle_o, "R7 idle after drain", idle_o, 1);
         check(pulses * MODV + sum_o == total, "R7 stream sum exact",
               pulses * MODV + sum_o, total);
      end

      // R7: saturating stream of maximum operands 6
      step(0, 1'b1);
      for (int n = 0; n < 200; n++) step(6, 1'b0);
      drain();
      check(pulses * MODV + sum_o == 1200, "R7 constant 6 stream",
            pulses * MODV + sum_o, 1200);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
      $finish;
   end

endmodule